// File: doc/BRIEF.md
# Snapshot Readout Frame Sequencer

This block sequences every frame of a snapshot-mode imager readout from a single pixel clock. Each frame opens with a one-cycle global pixel reset. A programmable integration window follows, during which the whole array collects charge at once. The selected rows are then scanned one after another, and a column and row address is given for every pixel read. Alongside the scan the block drives frame-valid, line-valid and data-valid strobes and a sample-clock enable for the downstream converter. Each of these four outputs can be switched off by configuration.

Two frame schedules are supported. In integrate-then-read, readout waits until integration has finished. In integrate-while-read, the scan of the stored frame runs alongside the next integration. When that integration is the longer of the two, the frame period is stretched to cover it. The scan covers a window of programmable position and size. The window can be sub-sampled 2:1, reading every other column and every other row, and each scan axis can be mirrored on its own. Configuration fields are written into a shadow bank by a one-cycle write strobe. The shadow bank is copied to the working bank only in the global-reset cycle, when no readout is in flight, so a frame never runs with mixed settings and no frame is dropped.

Top module: `snap_readout_seq`

## Requirements
- R1: While rst_n is low, glob_rst_o is 1 and integ_o, fval_o, lval_o, dval_o and samp_en_o are 0. Every frame starts with glob_rst_o high for exactly one cycle. integ_o is then high for exactly T cycles, where T is the working integration time; the first of these is the cycle after glob_rst_o.
- R2: With cfg_sched = 0 (integrate-then-read), no pixel is scanned while integ_o is high. The first pixel appears T+2 cycles after the glob_rst_o cycle. The next glob_rst_o comes T+R+3 cycles after the last one. R is the readout length, defined in R4.
- R3: With cfg_sched = 1 (integrate-while-read), the first pixel appears 2 cycles after glob_rst_o, so readout overlaps integration. The frame period is max(R+1, T+MIN_GAP)+2 cycles.
- R4: Each row drives lval_o high for W consecutive cycles, where W is the window column count. Between rows, lval_o is low for B cycles, where B = cfg_hblank, and a cfg_hblank of 0 acts as 1. fval_o stays high without a break from the first pixel to the last. R = W·H + (H−1)·B, where H is the window row count.
- R5: With mirroring and sub-sampling off, pixel i of a frame has col_addr_o = col_start + (i mod W) and row_addr_o = row_start + (i div W).
- R6: With cfg_subsamp = 1, the offset from the window start is doubled on both axes. The pixel count per row and the row count stay W and H.
- R7: cfg_mirror_h = 1 replaces the column offset k by W−1−k. cfg_mirror_v = 1 replaces the row offset j by H−1−j. The two axes are controlled independently.
- R8: A configuration write does not change the frame in progress. It takes effect from the frame whose glob_rst_o follows the write.
- R9: cfg_out_en bit 0 enables fval_o, bit 1 enables lval_o, bit 2 enables dval_o and bit 3 enables samp_en_o. A disabled output stays 0, and the enabled outputs keep their timing.
- R10: An integration time of 0 gives a frame in which integ_o never rises. In integrate-then-read, readout is then requested in the cycle after glob_rst_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe that loads all cfg fields into the shadow bank |
| cfg_sched | input | 1 | 0 integrate-then-read, 1 integrate-while-read |
| cfg_int_time | input | INT_W | Integration window in clocks |
| cfg_col_start | input | CA_W | First column of the window |
| cfg_col_len | input | CL_W | Pixels per row (0 acts as 1) |
| cfg_row_start | input | RA_W | First row of the window |
| cfg_row_len | input | RL_W | Rows per frame (0 acts as 1) |
| cfg_subsamp | input | 1 | 2:1 sub-sampling on both axes |
| cfg_mirror_h | input | 1 | Reverse column order |
| cfg_mirror_v | input | 1 | Reverse row order |
| cfg_hblank | input | HB_W | Blanking clocks between rows |
| cfg_out_en | input | 4 | Output enables: bit 0 fval, bit 1 lval, bit 2 dval, bit 3 sample clock |
| glob_rst_o | output | 1 | Global pixel reset |
| integ_o | output | 1 | Integration window |
| row_addr_o | output | RA_W | Row being read |
| col_addr_o | output | CA_W | Column being read |
| fval_o | output | 1 | Frame valid |
| lval_o | output | 1 | Line valid |
| dval_o | output | 1 | Pixel valid for the converter |
| samp_en_o | output | 1 | Enable for the gated sample clock |

## Verification
The two functions that can share a cycle are integration and line scanning. They meet in two ways. In integrate-while-read they run together on purpose. In integrate-then-read the integration ends in the very cycle that readout is requested. The bench provokes the overlap in two ways. It runs integrate-while-read with a short integration and counts the cycles in which integ_o and lval_o are both high; that count must be non-zero. It then runs a long integration and checks the stretched frame period. For the handoff it checks, in integrate-then-read, that the overlap count is zero and that the first pixel lands exactly T+2 cycles after the reset. The zero-length integration case checks the same handoff.

// File: rtl/snap_seq_pkg.sv
// Shared types for the snapshot readout frame sequencer.
// Assumes: nothing beyond the standard language.
package snap_seq_pkg;

    typedef enum logic {
        SCHED_ITR = 1'b0,
        SCHED_IWR = 1'b1
    } sched_e;

    typedef enum logic {
        PH_RST = 1'b0,
        PH_RUN = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_ACT  = 2'd1,
        SC_BLK  = 2'd2
    } scan_e;

endpackage

// File: rtl/snap_cfg_bank.sv
// Shadow and working configuration banks.
// The shadow bank captures all fields on a write strobe. The working bank
// copies the shadow bank when apply is high, and zero window lengths are
// forced to one during that copy.
// Assumes: apply is high only while no readout is in flight.
module snap_cfg_bank #(
    parameter int COLS       = 1280,
    parameter int ROWS       = 1024,
    parameter int INT_MAX    = 10_000_000,
    parameter int HB_W       = 8,
    parameter int DEF_INT    = 1000,
    parameter int DEF_HBLANK = 16,
    localparam int CA_W  = $clog2(COLS),
    localparam int CL_W  = $clog2(COLS + 1),
    localparam int RA_W  = $clog2(ROWS),
    localparam int RL_W  = $clog2(ROWS + 1),
    localparam int INT_W = $clog2(INT_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            apply,
    input  logic            in_sched,
    input  logic [INT_W-1:0] in_int,
    input  logic [CA_W-1:0] in_cs,
    input  logic [CL_W-1:0] in_cl,
    input  logic [RA_W-1:0] in_rs,
    input  logic [RL_W-1:0] in_rl,
    input  logic            in_sub,
    input  logic            in_mh,
    input  logic            in_mv,
    input  logic [HB_W-1:0] in_hb,
    input  logic [3:0]      in_en,
    output logic            act_sched,
    output logic [INT_W-1:0] act_int,
    output logic [CA_W-1:0] act_cs,
    output logic [CL_W-1:0] act_cl,
    output logic [RA_W-1:0] act_rs,
    output logic [RL_W-1:0] act_rl,
    output logic            act_sub,
    output logic            act_mh,
    output logic            act_mv,
    output logic [HB_W-1:0] act_hb,
    output logic [3:0]      act_en
);

    localparam logic [INT_W-1:0] RST_INT = INT_W'(DEF_INT);
    localparam logic [HB_W-1:0]  RST_HB  = HB_W'(DEF_HBLANK);
    localparam logic [CL_W-1:0]  RST_CL  = CL_W'(COLS);
    localparam logic [RL_W-1:0]  RST_RL  = RL_W'(ROWS);

    logic            sh_sched;
    logic [INT_W-1:0] sh_int;
    logic [CA_W-1:0] sh_cs;
    logic [CL_W-1:0] sh_cl;
    logic [RA_W-1:0] sh_rs;
    logic [RL_W-1:0] sh_rl;
    logic            sh_sub, sh_mh, sh_mv;
    logic [HB_W-1:0] sh_hb;
    logic [3:0]      sh_en;

    // Capture a complete field set into the shadow bank on a write.
    always_ff @(posedge clk) begin : p_shadow
        if (!rst_n) begin
            sh_sched <= 1'b0;
            sh_int   <= RST_INT;
            sh_cs    <= '0;
            sh_cl    <= RST_CL;
            sh_rs    <= '0;
            sh_rl    <= RST_RL;
            sh_sub   <= 1'b0;
            sh_mh    <= 1'b0;
            sh_mv    <= 1'b0;
            sh_hb    <= RST_HB;
            sh_en    <= 4'hF;
        end else if (wr) begin
            sh_sched <= in_sched;
            sh_int   <= in_int;
            sh_cs    <= in_cs;
            sh_cl    <= in_cl;
            sh_rs    <= in_rs;
            sh_rl    <= in_rl;
            sh_sub   <= in_sub;
            sh_mh    <= in_mh;
            sh_mv    <= in_mv;
            sh_hb    <= in_hb;
            sh_en    <= in_en;
        end
    end

    // Copy the shadow bank into the working bank at a frame boundary.
    always_ff @(posedge clk) begin : p_active
        if (!rst_n) begin
            act_sched <= 1'b0;
            act_int   <= RST_INT;
            act_cs    <= '0;
            act_cl    <= RST_CL;
            act_rs    <= '0;
            act_rl    <= RST_RL;
            act_sub   <= 1'b0;
            act_mh    <= 1'b0;
            act_mv    <= 1'b0;
            act_hb    <= RST_HB;
            act_en    <= 4'hF;
        end else if (apply) begin
            act_sched <= sh_sched;
            act_int   <= sh_int;
            act_cs    <= sh_cs;
            act_cl    <= (sh_cl == '0) ? CL_W'(1) : sh_cl;
            act_rs    <= sh_rs;
            act_rl    <= (sh_rl == '0) ? RL_W'(1) : sh_rl;
            act_sub   <= sh_sub;
            act_mh    <= sh_mh;
            act_mv    <= sh_mv;
            act_hb    <= sh_hb;
            act_en    <= sh_en;
        end
    end

endmodule

// File: rtl/snap_frame_ctrl.sv
// Frame phase controller. It drives a one-cycle global reset, then times
// the integration window. It asks the line scanner to start either at once
// (integrate-while-read) or when integration ends (integrate-then-read).
// The frame closes once the scan is done and, in integrate-while-read,
// once MIN_GAP clocks have passed after integration.
// Assumes: int_time and sched are held steady outside the reset cycle.
module snap_frame_ctrl
    import snap_seq_pkg::*;
#(
    parameter int INT_W   = 24,
    parameter int MIN_GAP = 16,
    localparam int GAP_W  = $clog2(MIN_GAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sched,
    input  logic [INT_W-1:0] int_time,
    input  logic             scan_busy,
    output logic             glob_rst,
    output logic             integ,
    output logic             scan_start
);

    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(MIN_GAP);

    phase_e           phase;
    logic [INT_W-1:0] int_cnt;
    logic [GAP_W-1:0] gap_cnt;
    logic             started;
    logic             int_done;
    logic             frame_end;

    // Decode the window, the scan request and the end-of-frame condition.
    always_comb begin : p_decode
        int_done   = (int_cnt == int_time);
        glob_rst   = (phase == PH_RST);
        integ      = (phase == PH_RUN) && !int_done;
        scan_start = (phase == PH_RUN) && !started &&
                     ((sched == SCHED_IWR) || int_done);
        frame_end  = (phase == PH_RUN) && started && !scan_busy &&
                     ((sched == SCHED_ITR) || (gap_cnt == GAP_LAST));
    end

    // Advance the frame phase and the integration and gap counters.
    always_ff @(posedge clk) begin : p_phase
        if (!rst_n) begin
            phase   <= PH_RST;
            int_cnt <= '0;
            gap_cnt <= '0;
            started <= 1'b0;
        end else if (phase == PH_RST) begin
            phase   <= PH_RUN;
            int_cnt <= '0;
            gap_cnt <= '0;
            started <= 1'b0;
        end else begin
            if (!int_done)
                int_cnt <= int_cnt + INT_W'(1);
            if (int_done && (gap_cnt != GAP_LAST))
                gap_cnt <= gap_cnt + GAP_W'(1);
            if (scan_start)
                started <= 1'b1;
            if (frame_end)
                phase <= PH_RST;
        end
    end

endmodule

// File: rtl/snap_line_scan.sv
// Window line scanner. It walks W pixels per row over H rows, with B
// blanking clocks between rows, and forms the column and row addresses
// from the window start, the optional 2:1 step and per-axis mirroring.
// Assumes: the window settings stay steady while busy is high, and the
// lengths given are non-zero.
module snap_line_scan
    import snap_seq_pkg::*;
#(
    parameter int COLS = 1280,
    parameter int ROWS = 1024,
    parameter int HB_W = 8,
    localparam int CA_W = $clog2(COLS),
    localparam int CL_W = $clog2(COLS + 1),
    localparam int RA_W = $clog2(ROWS),
    localparam int RL_W = $clog2(ROWS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CA_W-1:0] col_start,
    input  logic [CL_W-1:0] col_len,
    input  logic [RA_W-1:0] row_start,
    input  logic [RL_W-1:0] row_len,
    input  logic            sub,
    input  logic            mir_h,
    input  logic            mir_v,
    input  logic [HB_W-1:0] hblank,
    output logic            busy,
    output logic            active,
    output logic [CA_W-1:0] col_addr,
    output logic [RA_W-1:0] row_addr
);

    scan_e           st;
    logic [CL_W-1:0] col_idx;
    logic [RL_W-1:0] row_idx;
    logic [HB_W-1:0] blk_cnt;
    logic [HB_W-1:0] hb_last;
    logic [CL_W:0]   c_off, c_sum;
    logic [RL_W:0]   r_off, r_sum;

    // Last blanking count, with a zero setting treated as one clock.
    always_comb begin : p_hblast
        hb_last = (hblank == '0) ? '0 : hblank - HB_W'(1);
    end

    // Step through the pixels of a row, then blank, then the next row.
    always_ff @(posedge clk) begin : p_scan
        if (!rst_n) begin
            st      <= SC_IDLE;
            col_idx <= '0;
            row_idx <= '0;
            blk_cnt <= '0;
        end else begin
            case (st)
                SC_IDLE: if (start) begin
                    st      <= SC_ACT;
                    col_idx <= '0;
                    row_idx <= '0;
                end
                SC_ACT: if (col_idx == col_len - CL_W'(1)) begin
                    col_idx <= '0;
                    if (row_idx == row_len - RL_W'(1)) begin
                        st <= SC_IDLE;
                    end else begin
                        row_idx <= row_idx + RL_W'(1);
                        blk_cnt <= '0;
                        st      <= SC_BLK;
                    end
                end else begin
                    col_idx <= col_idx + CL_W'(1);
                end
                SC_BLK: if (blk_cnt == hb_last) st <= SC_ACT;
                        else blk_cnt <= blk_cnt + HB_W'(1);
                default: st <= SC_IDLE;
            endcase
        end
    end

    // Form the addresses from the offsets, the mirror bits and the step.
    always_comb begin : p_addr
        c_off = mir_h ? {1'b0, col_len - CL_W'(1) - col_idx} : {1'b0, col_idx};
        r_off = mir_v ? {1'b0, row_len - RL_W'(1) - row_idx} : {1'b0, row_idx};
        if (sub) begin
            c_off = c_off << 1;
            r_off = r_off << 1;
        end
        c_sum    = {{(CL_W + 1 - CA_W){1'b0}}, col_start} + c_off;
        r_sum    = {{(RL_W + 1 - RA_W){1'b0}}, row_start} + r_off;
        col_addr = c_sum[CA_W-1:0];
        row_addr = r_sum[RA_W-1:0];
        busy     = (st != SC_IDLE);
        active   = (st == SC_ACT);
    end

endmodule

// File: rtl/snap_readout_seq.sv
// Snapshot readout frame sequencer, top level. It joins the configuration
// banks, the frame phase controller and the line scanner, and gates the
// synchronisation outputs with the working output-enable bits.
// Assumes: a single pixel clock and a synchronous active-low reset.
module snap_readout_seq #(
    parameter int COLS       = 1280,
    parameter int ROWS       = 1024,
    parameter int INT_MAX    = 10_000_000,
    parameter int MIN_GAP    = 16,
    parameter int HB_W       = 8,
    parameter int DEF_INT    = 1000,
    parameter int DEF_HBLANK = 16,
    localparam int CA_W  = $clog2(COLS),
    localparam int CL_W  = $clog2(COLS + 1),
    localparam int RA_W  = $clog2(ROWS),
    localparam int RL_W  = $clog2(ROWS + 1),
    localparam int INT_W = $clog2(INT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sched,
    input  logic [INT_W-1:0] cfg_int_time,
    input  logic [CA_W-1:0]  cfg_col_start,
    input  logic [CL_W-1:0]  cfg_col_len,
    input  logic [RA_W-1:0]  cfg_row_start,
    input  logic [RL_W-1:0]  cfg_row_len,
    input  logic             cfg_subsamp,
    input  logic             cfg_mirror_h,
    input  logic             cfg_mirror_v,
    input  logic [HB_W-1:0]  cfg_hblank,
    input  logic [3:0]       cfg_out_en,
    output logic             glob_rst_o,
    output logic             integ_o,
    output logic [RA_W-1:0]  row_addr_o,
    output logic [CA_W-1:0]  col_addr_o,
    output logic             fval_o,
    output logic             lval_o,
    output logic             dval_o,
    output logic             samp_en_o
);

    logic             act_sched;
    logic [INT_W-1:0] act_int;
    logic [CA_W-1:0]  act_cs;
    logic [CL_W-1:0]  act_cl;
    logic [RA_W-1:0]  act_rs;
    logic [RL_W-1:0]  act_rl;
    logic             act_sub, act_mh, act_mv;
    logic [HB_W-1:0]  act_hb;
    logic [3:0]       act_en;
    logic             scan_busy, scan_act, scan_start;

    snap_cfg_bank #(
        .COLS(COLS), .ROWS(ROWS), .INT_MAX(INT_MAX), .HB_W(HB_W),
        .DEF_INT(DEF_INT), .DEF_HBLANK(DEF_HBLANK)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .apply(glob_rst_o),
        .in_sched(cfg_sched), .in_int(cfg_int_time),
        .in_cs(cfg_col_start), .in_cl(cfg_col_len),
        .in_rs(cfg_row_start), .in_rl(cfg_row_len),
        .in_sub(cfg_subsamp), .in_mh(cfg_mirror_h), .in_mv(cfg_mirror_v),
        .in_hb(cfg_hblank), .in_en(cfg_out_en),
        .act_sched(act_sched), .act_int(act_int),
        .act_cs(act_cs), .act_cl(act_cl), .act_rs(act_rs), .act_rl(act_rl),
        .act_sub(act_sub), .act_mh(act_mh), .act_mv(act_mv),
        .act_hb(act_hb), .act_en(act_en)
    );

    snap_frame_ctrl #(
        .INT_W(INT_W), .MIN_GAP(MIN_GAP)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sched(act_sched), .int_time(act_int),
        .scan_busy(scan_busy), .glob_rst(glob_rst_o), .integ(integ_o),
        .scan_start(scan_start)
    );

    snap_line_scan #(
        .COLS(COLS), .ROWS(ROWS), .HB_W(HB_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .start(scan_start),
        .col_start(act_cs), .col_len(act_cl),
        .row_start(act_rs), .row_len(act_rl),
        .sub(act_sub), .mir_h(act_mh), .mir_v(act_mv), .hblank(act_hb),
        .busy(scan_busy), .active(scan_act),
        .col_addr(col_addr_o), .row_addr(row_addr_o)
    );

    // Gate the synchronisation outputs with the working enable bits.
    always_comb begin : p_sync_out
        fval_o    = scan_busy & act_en[0];
        lval_o    = scan_act  & act_en[1];
        dval_o    = scan_act  & act_en[2];
        samp_en_o = scan_act  & act_en[3];
    end

endmodule

// File: rtl/snap_readout_seq_chk.sv
// Property checker for the snapshot readout frame sequencer. It is attached
// to every instance of the top module by the bind statement below.
// Assumes: rst_n is synchronous and active low.
module snap_readout_seq_chk #(
    parameter int INT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glob_rst,
    input logic             integ,
    input logic             scan_busy,
    input logic             sched_iwr,
    input logic [INT_W-1:0] int_time
);

    AST_RST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        glob_rst |=> !glob_rst); // R1

    AST_INTEG_FOLLOWS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(integ) |-> $past(glob_rst)); // R1

    AST_ITR_NO_SCAN_IN_INTEG: assert property (@(posedge clk) disable iff (!rst_n)
        (!sched_iwr && integ) |-> !scan_busy); // R2

    AST_APPLY_WITH_SCAN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        glob_rst |-> !scan_busy); // R8

    AST_CFG_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_rst |=> ($stable(int_time) && $stable(sched_iwr))); // R8

endmodule

bind snap_readout_seq snap_readout_seq_chk #(.INT_W(INT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .glob_rst(glob_rst_o), .integ(integ_o),
    .scan_busy(scan_busy), .sched_iwr(act_sched), .int_time(act_int)
);

// File: tb/snap_readout_seq_bench.sv
// Directed bench for the snapshot readout frame sequencer, on a small array.
module snap_readout_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int COLS = 16, ROWS = 8, INT_MAX = 1000, MIN_GAP = 4;
    localparam int HB_W = 4, DEF_INT = 5, DEF_HBLANK = 2;
    localparam int CA_W = $clog2(COLS), CL_W = $clog2(COLS + 1);
    localparam int RA_W = $clog2(ROWS), RL_W = $clog2(ROWS + 1);
    localparam int INT_W = $clog2(INT_MAX + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic b_wr = 1'b0, b_sched = 1'b0, b_sub = 1'b0, b_mh = 1'b0, b_mv = 1'b0;
    logic [INT_W-1:0] b_int = '0;
    logic [CA_W-1:0]  b_cs = '0;
    logic [CL_W-1:0]  b_cl = '0;
    logic [RA_W-1:0]  b_rs = '0;
    logic [RL_W-1:0]  b_rl = '0;
    logic [HB_W-1:0]  b_hb = '0;
    logic [3:0]       b_en = '0;
    logic glob_rst_o, integ_o, fval_o, lval_o, dval_o, samp_en_o;
    logic [RA_W-1:0] row_addr_o;
    logic [CA_W-1:0] col_addr_o;

    int vectors = 0, fails = 0;
    bit finished = 0;
    int m_integ, m_first, m_lv, m_dv, m_samp, m_fv, m_blank, m_ovl, m_period, m_px;
    int cap_col [0:255];
    int cap_row [0:255];

    always #(CLK_PERIOD / 2) clk = ~clk;

    snap_readout_seq #(
        .COLS(COLS), .ROWS(ROWS), .INT_MAX(INT_MAX), .MIN_GAP(MIN_GAP),
        .HB_W(HB_W), .DEF_INT(DEF_INT), .DEF_HBLANK(DEF_HBLANK)
    ) u_snap_readout_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(b_wr), .cfg_sched(b_sched),
        .cfg_int_time(b_int), .cfg_col_start(b_cs), .cfg_col_len(b_cl),
        .cfg_row_start(b_rs), .cfg_row_len(b_rl), .cfg_subsamp(b_sub),
        .cfg_mirror_h(b_mh), .cfg_mirror_v(b_mv), .cfg_hblank(b_hb),
        .cfg_out_en(b_en), .glob_rst_o(glob_rst_o), .integ_o(integ_o),
        .row_addr_o(row_addr_o), .col_addr_o(col_addr_o), .fval_o(fval_o),
        .lval_o(lval_o), .dval_o(dval_o), .samp_en_o(samp_en_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int sched, input int t, input int cs, input int cl,
                           input int rs, input int rl, input int sub, input int mh,
                           input int mv, input int hb, input int en);
        b_sched = sched[0];   b_int = INT_W'(t);
        b_cs = CA_W'(cs);     b_cl = CL_W'(cl);
        b_rs = RA_W'(rs);     b_rl = RL_W'(rl);
        b_sub = sub[0];       b_mh = mh[0];      b_mv = mv[0];
        b_hb = HB_W'(hb);     b_en = 4'(en);
    endtask

    // Follow one frame, starting at a sample where glob_rst_o is high.
    task automatic capture(input bit do_wr);
        int c = 0;
        m_integ = 0; m_first = -1; m_lv = 0; m_dv = 0; m_samp = 0;
        m_fv = 0; m_blank = 0; m_ovl = 0; m_px = 0;
        while (1) begin
            @(negedge clk);
            c++;
            if (glob_rst_o || c > 5000) break;
            if (integ_o) m_integ++;
            if (lval_o) m_lv++;
            if (dval_o) m_dv++;
            if (samp_en_o) m_samp++;
            if (fval_o) m_fv++;
            if (fval_o && !lval_o) m_blank++;
            if (integ_o && lval_o) m_ovl++;
            if (lval_o || dval_o) begin
                if (m_first < 0) m_first = c;
                if (m_px < 256) begin
                    cap_col[m_px] = int'(col_addr_o);
                    cap_row[m_px] = int'(row_addr_o);
                end
                m_px++;
            end
            b_wr = do_wr && (c == 3);
        end
        b_wr = 1'b0;
        m_period = c;
    endtask

    task automatic chk_addrs(input string req, input int cs, input int cl, input int rs,
                             input int rl, input bit sub, input bit mh, input bit mv);
        int bad = 0;
        for (int i = 0; i < cl * rl && i < 256; i++) begin
            int ci = i % cl, ri = i / cl;
            int co = mh ? cl - 1 - ci : ci;
            int ro = mv ? rl - 1 - ri : ri;
            int ec = cs + (sub ? 2 * co : co);
            int er = rs + (sub ? 2 * ro : ro);
            if (cap_col[i] != ec || cap_row[i] != er) bad++;
        end
        chk(req, "address mismatches", bad, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "glob_rst in reset", int'(glob_rst_o), 1);
        chk("R1", "integ in reset", int'(integ_o), 0);
        chk("R1", "fval/lval/dval/samp in reset",
            int'({fval_o, lval_o, dval_o, samp_en_o}), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_itr_default();
        capture(1'b0);
        chk("R1", "integ length", m_integ, 5);
        chk("R2", "first pixel cycle", m_first, 7);
        chk("R2", "integ/lval overlap", m_ovl, 0);
        chk("R2", "frame period", m_period, 150);
        chk("R4", "pixel count", m_lv, 128);
        chk("R4", "blank cycles", m_blank, 14);
        chk("R4", "fval length", m_fv, 142);
        chk_addrs("R5", 0, 16, 0, 8, 0, 0, 0);
    endtask

    task automatic t_iwr_short();
        set_cfg(1, 5, 0, 16, 0, 8, 0, 0, 0, 0, 15);
        capture(1'b1);
        chk("R8", "old frame period kept", m_period, 150);
        capture(1'b0);
        chk("R3", "first pixel cycle", m_first, 2);
        chk("R3", "integ/lval overlap seen", int'(m_ovl > 0), 1);
        chk("R3", "frame period", m_period, 138);
        chk("R4", "blank with hblank 0", m_blank, 7);
        chk("R4", "fval length", m_fv, 135);
    endtask

    task automatic t_iwr_long();
        set_cfg(1, 300, 0, 16, 0, 8, 0, 0, 0, 0, 15);
        capture(1'b1);
        chk("R8", "old frame period kept", m_period, 138);
        capture(1'b0);
        chk("R1", "integ length", m_integ, 300);
        chk("R3", "stretched period", m_period, 306);
        chk("R3", "fval length", m_fv, 135);
    endtask

    task automatic t_window();
        set_cfg(0, 0, 3, 4, 2, 3, 0, 0, 0, 3, 15);
        capture(1'b1);
        capture(1'b0);
        chk("R10", "integ length zero", m_integ, 0);
        chk("R10", "first pixel cycle", m_first, 2);
        chk("R2", "frame period", m_period, 21);
        chk("R4", "pixel count", m_lv, 12);
        chk("R4", "blank cycles", m_blank, 6);
        chk_addrs("R5", 3, 4, 2, 3, 0, 0, 0);
    endtask

    task automatic t_mirror_h();
        set_cfg(0, 0, 3, 4, 2, 3, 0, 1, 0, 3, 15);
        capture(1'b1);
        capture(1'b0);
        chk("R7", "pixel count", m_lv, 12);
        chk_addrs("R7", 3, 4, 2, 3, 0, 1, 0);
    endtask

    task automatic t_subsamp_mirror_v();
        set_cfg(0, 0, 1, 4, 0, 3, 1, 0, 1, 3, 15);
        capture(1'b1);
        capture(1'b0);
        chk("R6", "pixel count", m_lv, 12);
        chk("R6", "frame period", m_period, 21);
        chk_addrs("R6", 1, 4, 0, 3, 1, 0, 1);
    endtask

    task automatic t_enables_a();
        set_cfg(0, 0, 1, 4, 0, 3, 1, 0, 1, 3, 5);
        capture(1'b1);
        capture(1'b0);
        chk("R9", "lval disabled", m_lv, 0);
        chk("R9", "samp disabled", m_samp, 0);
        chk("R9", "dval count", m_dv, 12);
        chk("R9", "fval length", m_fv, 18);
    endtask

    task automatic t_enables_b();
        set_cfg(0, 0, 1, 4, 0, 3, 1, 0, 1, 3, 10);
        capture(1'b1);
        capture(1'b0);
        chk("R9", "fval disabled", m_fv, 0);
        chk("R9", "dval disabled", m_dv, 0);
        chk("R9", "lval count", m_lv, 12);
        chk("R9", "samp count", m_samp, 12);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_itr_default();
        t_iwr_short();
        t_iwr_long();
        t_window();
        t_mirror_h();
        t_subsamp_mirror_v();
        t_enables_a();
        t_enables_b();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule